// File: doc/BRIEF.md
# Multi-core interrupt pending aggregator

The block collects a set of level-sensitive interrupt sources and fans them out to several cores. Each core has a small group of pin outputs. Every source tracks a raw pending bit that follows its input level. Masking is per source, through enable words 32 bits wide. A source that is both pending and enabled is recorded in a status word that belongs to the core it is routed to. A core's pin output is high while any recorded source of that core is routed to that pin. A neighbouring decode block supplies, for every source, a target core and a pin number on the route inputs.

Software reaches the block through a plain 32-bit register port. Enable words can be read and written. Status words are clear-on-write-1. A status access always works on the word set of the core named on the requester-ID sideband. Address decode produces one of three regions: `RG_EN` (enable words), `RG_STAT` (status words of the requesting core) and `RG_NONE` (anything else). A change of enable replays or retracts sources that are already pending, so unmasking a source that is already asserted raises its core pin without a new input edge.

Top module: `irq_aggr_top`

## Requirements
- R1: While `rst_n` is low, all raw pending bits, enable bits and status bits clear to zero. `core_pin` is zero and register reads return zero until new state is built.
- R2: A source whose enable bit is 0 changes no status bit and no `core_pin` bit when its input rises. Its raw level is still tracked.
- R3: When an enabled source i rises, bit i%32 of status word i/32 of core `route_core[i]` is set. From the next cycle, bit `core*4+pin` of `core_pin` is high, where pin is `route_pin[i]`.
- R4: A pin bit of `core_pin` stays high while at least one recorded source of that core routed to that pin remains. It falls only when the last one is removed.
- R5: A write that takes an enable bit from 0 to 1 while the source input is high records the source as in R3, with no new input edge.
- R6: A write that takes an enable bit from 1 to 0 removes the source's status bit and its contribution to the pin.
- R7: A status write clears, only in the status word of the core given by `reg_req_id`, each bit written as 1. The status words of other cores are left alone.
- R8: A status read returns the addressed word of the core given by `reg_req_id`.
- R9: When an input falls, its status bit is removed and the pin is updated.
- R10: Accesses are 32 bits wide and must be word-aligned. The word index is byte offset >> 2. Enable words sit at byte 0x00 + 4k and status words at 0x40 + 4k, for k < N_SRC/32. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R11: A read of an unmapped or misaligned offset returns zero. A write to such an offset changes no enable bit, no status bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Source levels, one per source |
| route_core | input | 128 | Target core of source i in bits [2i+1:2i] |
| route_pin | input | 128 | Target pin of source i in bits [2i+1:2i] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset within the register region |
| reg_wdata | input | 32 | Write data |
| reg_req_id | input | 2 | Core issuing the access |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| core_pin | output | 16 | Pin outputs, bit core*4+pin |

## Verification
The bench builds the block with its default parameters: 64 sources, 4 cores and 4 pins per core. That gives two enable and status words, so the bench can reach word index 1 and also the first unmapped index 2. Routing source i to core i%4 and pin (i/4)%4 puts two sources on one core pin, which exercises the OR hold. It also sends sources in different words to different cores. Status accesses issued under two different requester IDs show that clears and reads are confined to the requesting core.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_EN   = 2'd1,
        RG_STAT = 2'd2
    } region_e;
endpackage

// File: rtl/aggr_regdec.sv
module aggr_regdec
    import aggr_pkg::*;
#(
    parameter int AW = 8,
    parameter int NW = 2,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [IW-1:0] idx
);
    localparam int FW = AW - 4;

    logic [FW-1:0] field;

    always_comb begin
        field  = addr[AW-3:2];
        idx    = field[IW-1:0];
        region = RG_NONE;
        if (addr[1:0] == 2'b00 && int'(field) < NW) begin
            unique case (addr[AW-1:AW-2])
                2'b00:   region = RG_EN;
                2'b01:   region = RG_STAT;
                default: region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/aggr_core_bank.sv
module aggr_core_bank #(
    parameter int N  = 64,
    parameter int NP = 4,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    set_vec,
    input  logic [N-1:0]    clr_vec,
    input  logic [N*PW-1:0] route_pin,
    output logic [N-1:0]    stat,
    output logic [NP-1:0]   pin_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat | set_vec) & ~clr_vec;
    end

    for (genvar p = 0; p < NP; p++) begin : g_pin
        always_comb begin
            pin_out[p] = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (stat[i] && int'(route_pin[i*PW +: PW]) == p) pin_out[p] = 1'b1;
            end
        end
    end

    // R7: a clear request always removes the bit on the next cycle
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((stat & $past(clr_vec)) == '0));

    // R3: a set without a matching clear is recorded
    p_set_records_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~clr_vec) != '0) |=>
        ((stat & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import aggr_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 4,
    parameter int AW     = 8,
    localparam int NW = N_SRC / 32,
    localparam int CW = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int PW = (N_PIN > 1) ? $clog2(N_PIN) : 1,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      irq_in,
    input  logic [N_SRC*CW-1:0]   route_core,
    input  logic [N_SRC*PW-1:0]   route_pin,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [AW-1:0]         reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic [CW-1:0]         reg_req_id,
    output logic [31:0]           reg_rdata,
    output logic [N_CORE*N_PIN-1:0] core_pin
);
    region_e          region;
    logic [IW-1:0]    widx;
    logic [N_SRC-1:0] raw_q, en_q, en_next;
    logic [N_SRC-1:0] live_now, live_q, rise_set, drop_clr;
    logic [N_SRC-1:0] stat_core [N_CORE];
    logic [N_SRC-1:0] stat_any;

    aggr_regdec #(.AW(AW), .NW(NW)) u_dec (
        .addr   (reg_addr),
        .region (region),
        .idx    (widx)
    );

    always_comb begin
        en_next = en_q;
        for (int w = 0; w < NW; w++) begin
            if (reg_wr && region == RG_EN && int'(widx) == w)
                en_next[w*32 +: 32] = reg_wdata;
        end
        live_now = irq_in & en_next;
        live_q   = raw_q & en_q;
        rise_set = live_now & ~live_q;
        drop_clr = live_q & ~live_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= irq_in;
            en_q  <= en_next;
        end
    end

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        logic [N_SRC-1:0] set_c, clr_c;
        always_comb begin
            for (int i = 0; i < N_SRC; i++)
                set_c[i] = rise_set[i] && int'(route_core[i*CW +: CW]) == c;
            clr_c = drop_clr;
            for (int w = 0; w < NW; w++) begin
                if (reg_wr && region == RG_STAT && int'(widx) == w && int'(reg_req_id) == c)
                    clr_c[w*32 +: 32] = clr_c[w*32 +: 32] | reg_wdata;
            end
        end
        aggr_core_bank #(.N(N_SRC), .NP(N_PIN)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_vec   (set_c),
            .clr_vec   (clr_c),
            .route_pin (route_pin),
            .stat      (stat_core[c]),
            .pin_out   (core_pin[c*N_PIN +: N_PIN])
        );
    end

    always_comb begin
        stat_any = '0;
        for (int c = 0; c < N_CORE; c++) stat_any = stat_any | stat_core[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (region)
                RG_EN:   reg_rdata <= en_q[int'(widx)*32 +: 32];
                RG_STAT: reg_rdata <= stat_core[reg_req_id][int'(widx)*32 +: 32];
                default: reg_rdata <= '0;
            endcase
        end
    end

    // R1: reset leaves every pin low
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (core_pin == '0));

    // R6: no core records a source whose enable bit is clear
    p_stat_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_any & ~en_q) == '0));

    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && region == RG_NONE) |=> (reg_rdata == '0));
endmodule

// File: tb/tb_irq_aggr_top.sv
`timescale 1ns/1ps
module tb_irq_aggr_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  irq_in = '0;
    logic [127:0] route_core, route_pin;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [1:0]   reg_req_id = '0;
    logic [31:0]  reg_rdata;
    logic [15:0]  core_pin;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb_q[$];
    logic mon_arm = 1'b0;

    always #2 clk = ~clk;

    irq_aggr_top dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .route_core(route_core), .route_pin(route_pin),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_req_id(reg_req_id),
        .reg_rdata(reg_rdata), .core_pin(core_pin)
    );

    always @(posedge clk) mon_arm <= reg_rd;

    always @(negedge clk) begin
        item_t it;
        if (mon_arm && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (reg_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] id);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_req_id = id;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] id,
                      input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a; reg_req_id = id;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_irq(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
    endtask

    task automatic chk_pin(input logic [15:0] e, input string tag);
        @(negedge clk);
        checks++;
        if (core_pin !== e) begin
            failures++;
            $display("FAIL %s core_pin actual=%h expected=%h", tag, core_pin, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // source i goes to core i%4, pin (i/4)%4
        for (int i = 0; i < 64; i++) begin
            route_core[i*2 +: 2] = 2'(i % 4);
            route_pin[i*2 +: 2]  = 2'((i / 4) % 4);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_pin(16'h0000, "R1 reset pins");
        rd(8'h00, 2'd0, 32'h0, "R1 enable word after reset");
        rd(8'h40, 2'd0, 32'h0, "R1 status word after reset");

        set_irq(0, 1'b1);
        chk_pin(16'h0000, "R2 masked rise");
        rd(8'h40, 2'd0, 32'h0, "R2 status untouched");

        wr(8'h00, 32'h1, 2'd0);
        chk_pin(16'h0001, "R5 replay on unmask");
        rd(8'h40, 2'd0, 32'h1, "R5 status after replay");
        rd(8'h00, 2'd0, 32'h1, "R10 enable readback");

        wr(8'h04, 32'h2, 2'd0);
        set_irq(33, 1'b1);
        chk_pin(16'h0011, "R3 src33 to core1 pin0");
        rd(8'h44, 2'd1, 32'h2, "R8 core1 status word1");
        rd(8'h44, 2'd0, 32'h0, "R8 core0 status word1");

        wr(8'h00, 32'h0001_0001, 2'd0);
        set_irq(16, 1'b1);
        rd(8'h40, 2'd0, 32'h0001_0001, "R3 two sources core0");
        wr(8'h40, 32'h1, 2'd0);
        chk_pin(16'h0011, "R4 pin held by src16");
        rd(8'h40, 2'd0, 32'h0001_0000, "R7 w1c bit0");
        wr(8'h40, 32'h0001_0000, 2'd1);
        rd(8'h40, 2'd0, 32'h0001_0000, "R7 other core write ignored");
        wr(8'h40, 32'h0001_0000, 2'd0);
        chk_pin(16'h0010, "R4 pin drops after last source");

        set_irq(33, 1'b0);
        chk_pin(16'h0000, "R9 fall removes src33");
        rd(8'h44, 2'd1, 32'h0, "R9 core1 status cleared");

        wr(8'h00, 32'h0001_0021, 2'd0);
        set_irq(5, 1'b1);
        chk_pin(16'h0020, "R3 src5 to core1 pin1");
        rd(8'h40, 2'd1, 32'h20, "R3 core1 status word0");
        wr(8'h00, 32'h0001_0001, 2'd0);
        chk_pin(16'h0000, "R6 mask withdraws src5");
        rd(8'h40, 2'd1, 32'h0, "R6 core1 status cleared");

        wr(8'h80, 32'hFFFF_FFFF, 2'd0);
        wr(8'h08, 32'hFFFF_FFFF, 2'd0);
        wr(8'h01, 32'hFFFF_FFFF, 2'd0);
        chk_pin(16'h0000, "R11 unmapped writes no effect");
        rd(8'h00, 2'd0, 32'h0001_0001, "R11 enable word0 kept");
        rd(8'h04, 2'd0, 32'h2, "R11 enable word1 kept");
        rd(8'h80, 2'd0, 32'h0, "R11 unmapped read");
        rd(8'h48, 2'd0, 32'h0, "R11 out-of-range index read");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule